// File: doc/BRIEF.md
# Delta-Modulated Sample Level Generator

This block holds the 7-bit output level of a delta-modulated sample channel. The level can be written directly from the processor side. It also moves up or down by two for each serial sample bit. Sample bits come from bytes delivered over a valid/ready stream. The block keeps one byte in a holding buffer and a second byte in a shift register, and it uses those bits up at a rate set by a 4-bit rate index.

Everything runs on one system clock. The bit rate is a clock enable produced by a reloading down-counter, so the direct write and the delta step act on the same register. If both happen in the same cycle, the direct write takes priority. Stepping stops at both rails, 0 and 126. When the buffer is empty at a byte boundary, the next eight bit slots are silent and the level holds.

Stream rules: `smp_ready` is high only while the channel is enabled and the holding buffer is empty. A byte is taken on a clock edge where `smp_valid` and `smp_ready` are both high. The producer must hold `smp_data` stable while `smp_valid` is high and `smp_ready` is low. Once a byte is taken, `smp_ready` drops until that byte has moved into the shift register at a byte boundary.

Top module: `dpcm_level_unit`

## Requirements
- R1: After reset the level is 0 and `smp_ready` is low while `enable` is low.
- R2: When `ld_valid` is high on a clock edge, the level after that edge equals `ld_data`. Later steps continue from that value.
- R3: Sample bits are used least significant bit first. A 1 bit adds 2 to the level and a 0 bit subtracts 2.
- R4: A step that would take the level above 126 or below 0 leaves it unchanged. A loaded level of 127 or 1 therefore does not move in the blocked direction.
- R5: When a direct write and a step fall on the same edge, the written value is kept and the step is dropped.
- R6: Bit slots are (16 - rate_idx) * STEP clock cycles apart, where rate_idx is sampled each time the timer reloads.
- R7: Every eighth bit slot is a byte boundary. At a boundary a buffered byte moves into the shift register; if none is buffered, the next eight slots are silent and the level does not change.
- R8: `smp_ready` equals `enable` AND (holding buffer empty). After an accepted byte it is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; gates byte requests |
| rate_idx | input | 4 | Bit-rate index; higher means faster |
| ld_valid | input | 1 | Direct level write strobe |
| ld_data | input | 7 | Direct level write value |
| smp_valid | input | 1 | Sample byte offered |
| smp_ready | output | 1 | Buffer empty, byte may be taken |
| smp_data | input | 8 | Sample byte |
| level | output | 7 | Current output level |

## Verification
A wrong bit counter or a shift register out of phase shows up as a final level that differs from the arithmetic walk of the byte's bits. This appears within sixteen bit slots of the byte being offered, and the bench checks every byte value from several starting levels, including both rails and the odd values next to them. A wrong timer reload shows up as the wrong gap between two successive level changes, which is measured for all sixteen rate indices. A holding buffer whose status is lost appears at once on `smp_ready`. A wrong load priority makes the level drift away from the written value during the overlap cycles.

// File: rtl/dpcm_pkg.sv
package dpcm_pkg;
  localparam int RATE_W = 4;
  localparam int RATE_N = 1 << RATE_W;

  // Cycles between bit slots for a given rate index.
  function automatic int bit_period(logic [RATE_W-1:0] idx, int step);
    return (RATE_N - int'(idx)) * step;
  endfunction
endpackage

// File: rtl/dpcm_rate_timer.sv
module dpcm_rate_timer #(
  parameter int STEP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rate_idx,
  output logic       tick
);
  localparam int MAXP = dpcm_pkg::RATE_N * STEP;
  localparam int CW   = $clog2(MAXP + 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= CW'(dpcm_pkg::bit_period(rate_idx, STEP) - 1);
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R6: counter never leaves its legal range
  p_period_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (int'(cnt_q) < MAXP));
endmodule

// File: rtl/dpcm_bit_shifter.sv
module dpcm_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         enable,
  input  logic         smp_valid,
  output logic         smp_ready,
  input  logic [W-1:0] smp_data,
  output logic         step_en,
  output logic         step_up
);
  localparam int BW = $clog2(W);

  logic [W-1:0]  hold_q;
  logic          hold_full_q;
  logic [W-1:0]  shreg_q;
  logic [BW-1:0] bcnt_q;
  logic          silent_q;
  logic          boundary;

  assign smp_ready = enable && !hold_full_q;
  assign step_en   = tick && !silent_q;
  assign step_up   = shreg_q[0];
  assign boundary  = (bcnt_q == BW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      shreg_q     <= '0;
      bcnt_q      <= BW'(W - 1);
      silent_q    <= 1'b1;
    end else begin
      if (smp_valid && smp_ready) begin
        hold_q      <= smp_data;
        hold_full_q <= 1'b1;
      end
      if (tick) begin
        if (boundary) begin
          bcnt_q <= '0;
          if (hold_full_q) begin
            shreg_q     <= hold_q;
            silent_q    <= 1'b0;
            hold_full_q <= 1'b0;
          end else begin
            silent_q <= 1'b1;
          end
        end else begin
          bcnt_q  <= bcnt_q + 1'b1;
          shreg_q <= shreg_q >> 1;
        end
      end
    end
  end

  // R8: an accepted byte fills the buffer, so the request drops
  p_accept_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);
  // R8: no request while disabled
  p_no_req_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !smp_ready);
endmodule

// File: rtl/dpcm_level_reg.sv
module dpcm_level_reg #(
  parameter int LW      = 7,
  parameter int STEP_SZ = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [LW-1:0] ld_data,
  input  logic          step_en,
  input  logic          step_up,
  output logic [LW-1:0] level
);
  localparam int RAIL_HI = (1 << LW) - 2;
  localparam int UP_MAX  = RAIL_HI - STEP_SZ;

  logic [LW-1:0] lvl_q;
  logic          can_up, can_dn;

  assign can_up = int'(lvl_q) <= UP_MAX;
  assign can_dn = int'(lvl_q) >= STEP_SZ;
  assign level  = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (ld_valid) begin
      lvl_q <= ld_data;
    end else if (step_en) begin
      if (step_up && can_up)        lvl_q <= lvl_q + LW'(STEP_SZ);
      else if (!step_up && can_dn)  lvl_q <= lvl_q - LW'(STEP_SZ);
    end
  end

  // R5 / R2: the write value is what follows a write edge
  p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (lvl_q == $past(ld_data)));
  // R3: without a write the level moves by the step size or not at all
  p_step_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> ((int'(lvl_q) == int'($past(lvl_q))) ||
                   (int'(lvl_q) == int'($past(lvl_q)) + STEP_SZ) ||
                   (int'(lvl_q) == int'($past(lvl_q)) - STEP_SZ)));
  // R4: stepping never passes the upper rail
  p_rail_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_valid && int'(lvl_q) <= RAIL_HI) |=> (int'(lvl_q) <= RAIL_HI));
  // R7: no slot, no write: the level holds
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_valid && !step_en) |=> $stable(lvl_q));
endmodule

// File: rtl/dpcm_level_unit.sv
module dpcm_level_unit #(
  parameter int STEP = 4,
  parameter int LW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [3:0]    rate_idx,
  input  logic          ld_valid,
  input  logic [LW-1:0] ld_data,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [7:0]    smp_data,
  output logic [LW-1:0] level
);
  logic tick, step_en, step_up;

  dpcm_rate_timer #(.STEP(STEP)) u_timer (
    .clk(clk), .rst_n(rst_n), .rate_idx(rate_idx), .tick(tick)
  );

  dpcm_bit_shifter #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .step_en(step_en), .step_up(step_up)
  );

  dpcm_level_reg #(.LW(LW), .STEP_SZ(2)) u_level (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
    .step_en(step_en), .step_up(step_up), .level(level)
  );

  // R7: a step only happens on a timer slot
  p_step_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> tick);
endmodule

// File: tb/test_dpcm_level_unit.sv
module test_dpcm_level_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] rate_idx = 4'd15;
  logic       ld_valid = 1'b0;
  logic [6:0] ld_data = '0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [7:0] smp_data = '0;
  logic [6:0] level;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dpcm_level_unit #(.STEP(1), .LW(7)) i_dpcm_level_unit (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate_idx(rate_idx),
    .ld_valid(ld_valid), .ld_data(ld_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .level(level)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int walk(input int start, input logic [7:0] b);
    int lv = start;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) begin
        if (lv <= 124) lv += 2;
      end else begin
        if (lv >= 2) lv -= 2;
      end
    end
    return lv;
  endfunction

  // Reset with a byte and a write pending; returns after edge 0.
  task automatic start_case(input int lv, input logic [7:0] b, input logic [3:0] idx);
    rst_n = 1'b0;
    enable = 1'b1; rate_idx = idx;
    smp_valid = 1'b1; smp_data = b;
    ld_valid = 1'b1; ld_data = 7'(lv);
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    ld_valid = 1'b0; smp_valid = 1'b0;
  endtask

  task automatic wait_change(input int from, output int at);
    at = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (int'(level) != from) begin at = cyc; break; end
    end
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int starts[8] = '{0, 1, 2, 60, 124, 125, 126, 127};
    // R1: reset state
    @(posedge clk); @(negedge clk);
    check(level == 7'd0, "R1 level", int'(level), 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(smp_ready == 1'b0, "R1 ready while disabled", int'(smp_ready), 0);
    check(level == 7'd0, "R1 level after release", int'(level), 0);

    // R2 R3 R4: every byte from several start levels
    foreach (starts[s]) begin
      for (int b = 0; b < 256; b++) begin
        start_case(starts[s], 8'(b), 4'd15);
        repeat (20) @(negedge clk);
        check(int'(level) == walk(starts[s], 8'(b)), "R3/R4 walk",
              int'(level), walk(starts[s], 8'(b)));
      end
    end

    // R7: silence after the byte, level holds
    start_case(60, 8'hFF, 4'd15);
    repeat (20) @(negedge clk);
    check(level == 7'd76, "R7 after byte", int'(level), 76);
    repeat (24) @(negedge clk);
    check(level == 7'd76, "R7 silent hold", int'(level), 76);

    // R8: request handshake
    start_case(0, 8'h00, 4'd15);
    check(smp_ready == 1'b0, "R8 ready low after accept", int'(smp_ready), 0);
    repeat (10) @(negedge clk);
    check(smp_ready == 1'b1, "R8 ready after move", int'(smp_ready), 1);
    enable = 1'b0;
    #0;
    check(smp_ready == 1'b0, "R8 ready follows enable", int'(smp_ready), 0);

    // R5 R2: writes during bit slots (slots at edges 9..16)
    start_case(0, 8'hFF, 4'd15);
    ld_valid = 1'b1; ld_data = 7'd40;
    for (int e = 1; e <= 12; e++) begin
      @(posedge clk); @(negedge clk);
      if (e >= 9) check(level == 7'd40, "R5 write beats step", int'(level), 40);
    end
    ld_valid = 1'b0;
    repeat (10) @(negedge clk);
    check(level == 7'd48, "R2 steps continue from written value", int'(level), 48);

    // R6: slot spacing for every rate index
    for (int idx = 0; idx < 16; idx++) begin
      int t1, t2;
      start_case(0, 8'hFF, 4'(idx));
      wait_change(0, t1);
      wait_change(int'(level), t2);
      check((t2 - t1) == (16 - idx), "R6 slot spacing", t2 - t1, 16 - idx);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule